// File: doc/BRIEF.md
# Packed Default Attribute Loader

This block sits on a register-write bus and fills a table of default vertex attribute vectors. Software first sets a target slot through an index register. It then streams 32-bit data words to any of three data addresses. Each vector has four 24-bit floating-point components, which together occupy exactly 96 bits. Every third accepted data word therefore completes one vector. The block splits the three words into components and stores the vector in the slot named by the index register. It then advances the index, so that a run of word triples fills consecutive slots.

If a vector completes while the index points past the end of the table, nothing is stored, the index stays where it is, and a one-cycle error pulse is raised. Any table entry can be read at any time through a combinational read port.

Top module: `default_attr_loader`

## Requirements
- R1: After reset, every table entry reads zero, the index output is 0, the error output is low, and the word count is 0 (the next three data writes form a complete vector).
- R2: A write with a nonzero byte mask to address 0x233, 0x234 or 0x235 stages one word, whichever of the three addresses is used and in any order. The third staged word completes a vector, and the word count restarts at zero.
- R3: For staged words A, B, C (in arrival order), the stored components are w = A[31:8], z = {A[7:0], B[31:16]}, y = {B[15:0], C[31:24]} and x = C[23:0]. The read port returns {w, z, y, x}, with w in bits [95:72] and x in bits [23:0].
- R4: When a vector completes with index below 16, it is written to that entry in the same clock edge, and the index output increments by one on that edge.
- R5: When a vector completes with index 16 or above, no entry changes and the index holds its value. The error output is high for exactly the one cycle after that edge.
- R6: A write with a nonzero mask to address 0x232 restarts the word count at zero, which discards a partial group. If mask bit 0 is set, the index is loaded from data bits [7:0].
- R7: Data bytes whose mask bit is clear are staged as zero (mask bit n covers data bits [8n+7:8n]). A write whose mask is all zero has no effect at all.
- R8: Writes to any address other than 0x232 to 0x235 change neither the index, the word count, the table, nor the error output.
- R9: The read port shows the entry selected by the read index in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Register word address |
| wr_data_i | input | 32 | Write data |
| wr_mask_i | input | 4 | Byte enables for write data |
| rd_idx_i | input | 4 | Table entry to read |
| rd_vec_o | output | 96 | Selected entry, {w, z, y, x} |
| idx_o | output | 8 | Current index register value |
| err_o | output | 1 | One-cycle pulse on an out-of-range store |

## Verification
The bench uses distinct byte patterns in every word, so that a design that shifts a straddling byte by one position, or reverses the component order, stores a visibly different vector. It interleaves the three data addresses to catch a design that ties the group position to the address rather than to the arrival count. It breaks off a partial group with an index write; a design that kept the stale words would misplace every later vector. It drives the index to 15, 16 and 200 to catch an off-by-one bound, a store that goes through on an error, an index that advances on an error, or an error pulse that lasts more than one cycle.

// File: rtl/default_attr_pkg.sv
package default_attr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned COMP_W    = 24;
  localparam int unsigned NUM_COMP  = 4;
  localparam int unsigned GRP_WORDS = 3;
  localparam int unsigned VEC_W     = COMP_W * NUM_COMP;
  localparam int unsigned BYTES     = WORD_W / 8;

  typedef logic [COMP_W-1:0] comp_t;

  // w occupies the top slice, x the bottom
  typedef struct packed {
    comp_t w;
    comp_t z;
    comp_t y;
    comp_t x;
  } attr_vec_t;
endpackage

// File: rtl/attr_stage.sv
module attr_stage #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 3,
  parameter int unsigned CNT_W  = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    push_i,
  input  logic [WORD_W-1:0]       word_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    done_o,
  output logic [DEPTH*WORD_W-1:0] group_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-2:0][WORD_W-1:0] held_q;

  assign done_o = push_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (done_o)   cnt_q <= '0;
    else if (push_i)   cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        held_q[k] <= '0;
      else if (push_i && !clear_i && cnt_q == CNT_W'(k))
        held_q[k] <= word_i;
    end
    // earliest word lands in the most significant slice
    assign group_o[WORD_W*(DEPTH-1-k) +: WORD_W] = held_q[k];
  end

  assign group_o[WORD_W-1:0] = word_i;
endmodule

// File: rtl/attr_unpack.sv
module attr_unpack
  import default_attr_pkg::*;
(
  input  logic [GRP_WORDS*WORD_W-1:0] group_i,
  output attr_vec_t                   vec_o
);
  logic [NUM_COMP-1:0][COMP_W-1:0] comps;

  // components are consecutive 24-bit slices of the 96-bit stream, w first
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    assign comps[c] = group_i[COMP_W*c +: COMP_W];
  end

  assign vec_o.x = comps[0];
  assign vec_o.y = comps[1];
  assign vec_o.z = comps[2];
  assign vec_o.w = comps[3];
endmodule

// File: rtl/attr_table.sv
module attr_table
  import default_attr_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned WA_W    = 8,
  parameter int unsigned RA_W    = $clog2(ENTRIES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [WA_W-1:0] waddr_i,
  input  attr_vec_t       wdata_i,
  input  logic [RA_W-1:0] raddr_i,
  output attr_vec_t       rdata_o
);
  attr_vec_t mem_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[e] <= '0;
      else if (we_i && waddr_i == WA_W'(e))
        mem_q[e] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/default_attr_loader.sv
module default_attr_loader
  import default_attr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [9:0]  BASE_ADDR = 10'h232,
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned RD_W      = $clog2(ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic [BYTES-1:0]     wr_mask_i,
  input  logic [RD_W-1:0]      rd_idx_i,
  output logic [VEC_W-1:0]     rd_vec_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 err_o
);
  localparam int unsigned CNT_W = $clog2(GRP_WORDS);
  localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_ADDR);

  logic [WORD_W-1:0] word_m;
  logic              wr_live, idx_hit, dat_hit;
  logic              done, in_range;
  logic [CNT_W-1:0]  stage_cnt;
  logic [GRP_WORDS*WORD_W-1:0] group;
  attr_vec_t         vec, rd_vec;
  logic [IDX_W-1:0]  idx_q;
  logic              err_q;

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign word_m[8*b +: 8] = wr_mask_i[b] ? wr_data_i[8*b +: 8] : 8'h00;
  end

  assign wr_live = wr_en_i && (|wr_mask_i);
  assign idx_hit = wr_live && (wr_addr_i == IDX_ADDR);
  assign dat_hit = wr_live && (wr_addr_i > IDX_ADDR) &&
                   (wr_addr_i <= IDX_ADDR + ADDR_W'(GRP_WORDS));
  assign in_range = idx_q < IDX_W'(ENTRIES);

  attr_stage #(.WORD_W(WORD_W), .DEPTH(GRP_WORDS), .CNT_W(CNT_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (idx_hit),
    .push_i  (dat_hit),
    .word_i  (word_m),
    .cnt_o   (stage_cnt),
    .done_o  (done),
    .group_o (group)
  );

  attr_unpack u_unpack (
    .group_i (group),
    .vec_o   (vec)
  );

  attr_table #(.ENTRIES(ENTRIES), .WA_W(IDX_W), .RA_W(RD_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done && in_range),
    .waddr_i (idx_q),
    .wdata_i (vec),
    .raddr_i (rd_idx_i),
    .rdata_o (rd_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= done && !in_range;
      if (idx_hit && wr_mask_i[0])
        idx_q <= word_m[IDX_W-1:0];
      else if (done && in_range)
        idx_q <= idx_q + 1'b1;
    end
  end

  assign rd_vec_o = rd_vec;
  assign idx_o    = idx_q;
  assign err_o    = err_q;
endmodule

// File: rtl/default_attr_loader_chk.sv
module default_attr_loader_chk #(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [9:0]  BASE_ADDR = 10'h232,
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CNT_W     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [IDX_W-1:0]  idx_data_i,
  input logic [3:0]        wr_mask_i,
  input logic [IDX_W-1:0]  idx_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  stage_cnt_i
);
  localparam logic [ADDR_W-1:0] IA = ADDR_W'(BASE_ADDR);

  logic live, iw, dw, fin;
  assign live = wr_en_i && (|wr_mask_i);
  assign iw   = live && wr_addr_i == IA;
  assign dw   = live && (wr_addr_i == IA + 1 || wr_addr_i == IA + 2 || wr_addr_i == IA + 3);
  assign fin  = dw && stage_cnt_i == CNT_W'(2);

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_cnt_i <= CNT_W'(2));

  assert_index_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iw && wr_mask_i[0] |=> idx_o == $past(idx_data_i));

  assert_group_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iw |=> stage_cnt_i == '0);

  assert_index_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && idx_o < IDX_W'(ENTRIES) |=> idx_o == IDX_W'($past(idx_o) + 1'b1));

  assert_reject_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && idx_o >= IDX_W'(ENTRIES) |=> err_o && $stable(idx_o));

  assert_err_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iw || dw) |=> $stable(idx_o) && $stable(stage_cnt_i) && !err_o);
endmodule

bind default_attr_loader default_attr_loader_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ENTRIES(ENTRIES),
  .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .idx_data_i  (wr_data_i[IDX_W-1:0]),
  .wr_mask_i   (wr_mask_i),
  .idx_o       (idx_o),
  .err_o       (err_o),
  .stage_cnt_i (stage_cnt)
);

// File: tb/default_attr_loader_tb.sv
module default_attr_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [9:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  wr_mask_i = '0;
  logic [3:0]  rd_idx_i = '0;
  logic [95:0] rd_vec_o;
  logic [7:0]  idx_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  // reference model state
  logic [95:0] m_tbl [16];
  logic [31:0] m_stg [$];
  int          m_idx = 0;
  bit          m_err = 0;

  default_attr_loader u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wr_mask_i(wr_mask_i), .rd_idx_i(rd_idx_i),
    .rd_vec_o(rd_vec_o), .idx_o(idx_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [95:0] pack3(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [23:0] w, z, y, x;
    w = a[31:8];
    z = {a[7:0], b[31:16]};
    y = {b[15:0], c[31:24]};
    x = c[23:0];
    return {w, z, y, x};
  endfunction

  initial for (int i = 0; i < 16; i++) m_tbl[i] = '0;

  always @(posedge clk_i) begin
    logic [31:0] m;
    m_err = 0;
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) m_tbl[i] = '0;
      m_stg.delete();
      m_idx = 0;
    end else if (wr_en_i && wr_mask_i != 0) begin
      for (int b = 0; b < 4; b++) m[8*b +: 8] = wr_mask_i[b] ? wr_data_i[8*b +: 8] : 8'h00;
      if (wr_addr_i == 10'h232) begin
        m_stg.delete();
        if (wr_mask_i[0]) m_idx = m[7:0];
      end else if (wr_addr_i >= 10'h233 && wr_addr_i <= 10'h235) begin
        m_stg.push_back(m);
        if (m_stg.size() == 3) begin
          if (m_idx < 16) begin
            m_tbl[m_idx] = pack3(m_stg[0], m_stg[1], m_stg[2]);
            m_idx = m_idx + 1;
          end else m_err = 1;
          m_stg.delete();
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of index and error against the model
  always @(negedge clk_i) if (rst_ni && !done_run) begin
    chk(idx_o == 8'(m_idx), "R4 index", 96'(idx_o), 96'(m_idx));
    chk(err_o == m_err, "R5 error", 96'(err_o), 96'(m_err));
  end

  task automatic wr(logic [9:0] a, logic [31:0] d, logic [3:0] mk = 4'hF);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d; wr_mask_i = mk;
    @(negedge clk_i);
    wr_en_i = 0; wr_mask_i = 0;
  endtask

  task automatic rd_chk(int e, logic [95:0] exp, string tag);
    rd_idx_i = 4'(e);
    #1;
    chk(rd_vec_o == exp, tag, rd_vec_o, exp);
  endtask

  task automatic table_chk(string tag);
    for (int e = 0; e < 16; e++) rd_chk(e, m_tbl[e], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(idx_o == 0 && err_o == 0, "R1 reset outputs", {idx_o, err_o}, '0);
    for (int e = 0; e < 16; e++) rd_chk(e, '0, "R1 table zero");

    // R3 field mapping into entry 0
    wr(10'h233, 32'h11223344);
    wr(10'h234, 32'h55667788);
    wr(10'h235, 32'h99AABBCC);
    rd_chk(0, 96'h112233_445566_778899_AABBCC, "R3 unpack order");
    chk(idx_o == 1, "R4 advance", 96'(idx_o), 96'd1);

    // R2 same address three times, R9 combinational read
    wr(10'h234, 32'hA1B2C3D4);
    wr(10'h234, 32'hE5F60718);
    wr(10'h234, 32'h293A4B5C);
    rd_chk(1, pack3(32'hA1B2C3D4, 32'hE5F60718, 32'h293A4B5C), "R2 any data address");
    rd_chk(0, 96'h112233_445566_778899_AABBCC, "R9 read select");

    // R6 partial group discarded by index write
    wr(10'h235, 32'hDEADBEEF);
    wr(10'h233, 32'hCAFEF00D);
    wr(10'h232, 32'h00000005);
    chk(idx_o == 5, "R6 index load", 96'(idx_o), 96'd5);
    wr(10'h235, 32'h01020304);
    wr(10'h233, 32'h05060708);
    chk(idx_o == 5, "R6 no early store", 96'(idx_o), 96'd5);
    wr(10'h234, 32'h090A0B0C);
    rd_chk(5, pack3(32'h01020304, 32'h05060708, 32'h090A0B0C), "R6 fresh group");
    rd_chk(2, '0, "R6 entry untouched");

    // R6 index write without mask bit 0: count restarts, index held
    wr(10'h233, 32'h77777777);
    wr(10'h232, 32'h0000000A, 4'b0010);
    chk(idx_o == 6, "R6 index held", 96'(idx_o), 96'd6);

    // R7 byte masking and all-zero mask
    wr(10'h233, 32'hFFFFFFFF, 4'b0101);
    wr(10'h234, 32'h12345678, 4'b0000);
    wr(10'h234, 32'hFFFFFFFF, 4'b1010);
    wr(10'h235, 32'h87654321);
    rd_chk(6, pack3(32'h00FF00FF, 32'hFF00FF00, 32'h87654321), "R7 mask");

    // R8 foreign addresses
    wr(10'h231, 32'h00000003);
    wr(10'h236, 32'hABCDEF01);
    wr(10'h000, 32'h00000002);
    chk(idx_o == 7, "R8 foreign ignored", 96'(idx_o), 96'd7);
    table_chk("R8 table intact");

    // fill remaining entries from index 7
    s = 32'h13579BDF;
    for (int v = 7; v < 16; v++) begin
      for (int k = 0; k < 3; k++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        wr(10'h233 + 10'(k), s);
      end
    end
    chk(idx_o == 16, "R4 reach end", 96'(idx_o), 96'd16);
    table_chk("R4 fill");

    // R5 out of range at 16
    wr(10'h233, 32'h11111111);
    wr(10'h234, 32'h22222222);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 10'h235; wr_data_i = 32'h33333333; wr_mask_i = 4'hF;
    @(negedge clk_i);
    wr_en_i = 0; wr_mask_i = 0;
    chk(err_o == 1 && idx_o == 16, "R5 error raised", {err_o, idx_o}, {1'b1, 8'd16});
    @(negedge clk_i);
    chk(err_o == 0, "R5 single pulse", 96'(err_o), '0);
    table_chk("R5 no store");

    // R5 far out of range
    wr(10'h232, 32'h000000C8);
    wr(10'h233, 32'h44444444);
    wr(10'h233, 32'h55555555);
    wr(10'h233, 32'h66666666);
    chk(idx_o == 200, "R5 index stays", 96'(idx_o), 96'd200);
    table_chk("R5 no store high");

    // wrap back to slot 15
    wr(10'h232, 32'h0000000F);
    wr(10'h235, 32'h0F0E0D0C);
    wr(10'h234, 32'h0B0A0908);
    wr(10'h233, 32'h07060504);
    rd_chk(15, pack3(32'h0F0E0D0C, 32'h0B0A0908, 32'h07060504), "R3 last slot");

    repeat (2) @(negedge clk_i);
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule